// File: doc/BRIEF.md
# Posted Write Buffer with Deferred Error Capture

This block sits between a processor's data port and a single memory bus. Committed stores are taken into a small first-in first-out queue and acknowledged straight away, so the processor never waits for the memory write. The queue drains to memory whenever the bus has nothing better to do. A read request always gets the bus first. A read whose address matches a queued store is answered from the queue, so a read never sees data older than the processor's own last store.

Because the store has already completed from the processor's point of view, a bus error on a drained write cannot be returned as a response to any access. Instead the block raises a one-cycle error pulse for the abort logic. It also logs the failing address in a capture register, which holds the first failure until software clears it. Any further failure in the meantime only sets an overflow flag.

Top module: `pwb_top`

## Requirements
- R1: After reset the queue is empty: `stReady` is 1, and `busReq`, `rdRespValid`, `errPulse`, `capValid` and `capOverflow` are 0.
- R2: A store is taken in the cycle where `stValid` and `stReady` are both 1, with no bus transaction needed. `stReady` is 0 while DEPTH stores are held, and also while `rdValid` is 1.
- R3: Queued stores go to the bus strictly in arrival order, one transaction at a time (`busWrite`=1). Address and data stay stable while `busReq` is held waiting for `busReady`.
- R4: When the block is between transactions and `rdValid` is 1, the read is served before any queued store starts draining, even if stores were queued first.
- R5: A read whose address matches one or more queued stores returns the newest matching store's data. `rdRespValid` is 1 in the same cycle, and no bus read is made.
- R6: A read with no match issues a bus read (`busWrite`=0). `rdRespValid` is 1 in the cycle `busReady` is 1, and `rdRespData` equals `busRData`.
- R7: A drained store that completes with `busErr`=1 makes `errPulse` 1 for exactly the following cycle.
- R8: On a failing store with `capValid`=0, `capAddr` takes that store's address and `capValid` becomes 1 from the next cycle.
- R9: On a failing store while `capValid`=1 (and no clear that cycle), `capOverflow` becomes 1 and `capAddr` keeps its value.
- R10: `capClear`=1 clears `capValid` and `capOverflow` in the next cycle. If a store fails in the same cycle, that failure is logged as a fresh first capture, with `capOverflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store offered |
| stReady | output | 1 | Store taken when high with stValid |
| stAddr | input | AW | Store address |
| stData | input | DW | Store data |
| rdValid | input | 1 | Read request, held until rdRespValid |
| rdAddr | input | AW | Read address, held with rdValid |
| rdRespValid | output | 1 | Read data valid this cycle |
| rdRespData | output | DW | Read data |
| busReq | output | 1 | Bus transaction requested |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | AW | Bus address |
| busWData | output | DW | Bus write data |
| busReady | input | 1 | Transaction completes this cycle |
| busRData | input | DW | Bus read data, valid with busReady |
| busErr | input | 1 | Error status, valid with busReady |
| capClear | input | 1 | Clear the error capture |
| errPulse | output | 1 | One-cycle deferred write error |
| capValid | output | 1 | A failing address is logged |
| capOverflow | output | 1 | More failures after the logged one |
| capAddr | output | AW | Address of the first failing store |

## Verification
Two cases can fall in the same cycle. In the first, a read request can arrive just as a queued store would begin to drain. The bench provokes this by raising `rdValid` while a slow write is in flight with a second store queued. It then judges the order from a log of bus transactions, which must show the read ahead of the second write. In the second, a failing store can complete in the cycle software clears the capture. The bench drives `capClear` in exactly the cycle where `busErr` is seen with `busReady`. It then checks that the capture holds the new address with the overflow flag low.

// File: rtl/pwb_pkg.sv
`timescale 1ns/1ps
package pwb_pkg;
  typedef enum logic [1:0] {S_IDLE, S_RBUS, S_WBUS} pwbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;     // take the offered store
    logic pop;      // retire the head store
    logic errHit;   // head store completed with an error
    logic selRead;  // bus address and response come from the read path
  } pwbStrobe_t;
endpackage

// File: rtl/pwb_ctrl.sv
`timescale 1ns/1ps
module pwb_ctrl
  import pwb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stValid,
  output logic       stReady,
  input  logic       rdValid,
  output logic       rdRespValid,
  output logic       busReq,
  output logic       busWrite,
  input  logic       busReady,
  input  logic       busErr,
  input  logic       full,
  input  logic       empty,
  input  logic       hit,
  output pwbStrobe_t strobe
);
  pwbState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // stores wait while a read is outstanding so forwarding sees a settled queue
  assign stReady = !full && !rdValid;

  always_comb begin
    stateNext      = state;
    busReq         = 1'b0;
    busWrite       = 1'b0;
    rdRespValid    = 1'b0;
    strobe         = '0;
    strobe.push    = stValid && stReady;
    strobe.selRead = (state == S_RBUS);
    case (state)
      S_IDLE: begin
        if (rdValid) begin
          if (hit) rdRespValid = 1'b1;
          else     stateNext   = S_RBUS;
        end else if (!empty) begin
          stateNext = S_WBUS;
        end
      end
      S_RBUS: begin
        busReq = 1'b1;
        if (busReady) begin
          rdRespValid = 1'b1;
          stateNext   = S_IDLE;
        end
      end
      S_WBUS: begin
        busReq   = 1'b1;
        busWrite = 1'b1;
        if (busReady) begin
          strobe.pop    = 1'b1;
          strobe.errHit = busErr;
          stateNext     = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  // R4: a pending read at an idle point keeps the next transaction off the write path
  assert_read_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && rdValid) |=> !(busReq && busWrite));

  // R2: nothing is pushed while a read waits
  assert_no_store_during_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !strobe.push);

  // R3: a write request is held with its direction until accepted
  assert_write_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && !busReady) |=> (busReq && busWrite));
endmodule

// File: rtl/pwb_datapath.sv
`timescale 1ns/1ps
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4   // power of two, at least 2
)(
  input  logic          clk,
  input  logic          rstN,
  input  pwbStrobe_t    strobe,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdRespData,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWData,
  input  logic [DW-1:0] busRData,
  input  logic          capClear,
  output logic          errPulse,
  output logic          capValid,
  output logic          capOverflow,
  output logic [AW-1:0] capAddr,
  output logic          full,
  output logic          empty,
  output logic          hit
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addrMem [DEPTH];
  logic [DW-1:0] dataMem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic [DW-1:0] fwdData;
  logic [AW-1:0] headAddr;
  logic          keepValid;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign headAddr = addrMem[rdPtr];
  assign busWData = dataMem[rdPtr];
  assign busAddr  = strobe.selRead ? rdAddr : headAddr;
  assign rdRespData = strobe.selRead ? busRData : fwdData;

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrMem[wrPtr] <= stAddr;
      dataMem[wrPtr] <= stData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // scan oldest to newest; the last match is the newest store
  always_comb begin
    hit     = 1'b0;
    fwdData = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CW'(i) < count) && (addrMem[rdPtr + PW'(i)] == rdAddr)) begin
        hit     = 1'b1;
        fwdData = dataMem[rdPtr + PW'(i)];
      end
    end
  end

  assign keepValid = capValid && !capClear;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errPulse    <= 1'b0;
      capValid    <= 1'b0;
      capOverflow <= 1'b0;
      capAddr     <= '0;
    end else begin
      errPulse <= strobe.errHit;
      if (strobe.errHit && keepValid) begin
        capOverflow <= 1'b1;
      end else if (strobe.errHit) begin
        capValid    <= 1'b1;
        capOverflow <= 1'b0;
        capAddr     <= headAddr;
      end else if (capClear) begin
        capValid    <= 1'b0;
        capOverflow <= 1'b0;
      end
    end
  end

  // R2: the control never pushes into a full queue
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !full);

  // R7: a failing completion is reported on the following cycle
  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.errHit |=> errPulse);

  // R8: first failure is logged with the retiring store's address
  assert_first_capture_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.errHit && !capValid) |=> (capValid && capAddr == $past(headAddr)));

  // R9: later failures leave the logged address alone
  assert_capture_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.errHit && capValid && !capClear) |=> (capOverflow && $stable(capAddr)));

  // R10: clearing without a new failure empties the capture
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (capClear && !strobe.errHit) |=> (!capValid && !capOverflow));
endmodule

// File: rtl/pwb_top.sv
`timescale 1ns/1ps
module pwb_top
  import pwb_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          stValid,
  output logic          stReady,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic          rdValid,
  input  logic [AW-1:0] rdAddr,
  output logic          rdRespValid,
  output logic [DW-1:0] rdRespData,
  output logic          busReq,
  output logic          busWrite,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWData,
  input  logic          busReady,
  input  logic [DW-1:0] busRData,
  input  logic          busErr,
  input  logic          capClear,
  output logic          errPulse,
  output logic          capValid,
  output logic          capOverflow,
  output logic [AW-1:0] capAddr
);
  pwbStrobe_t strobe;
  logic full, empty, hit;

  pwb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
    .rdValid(rdValid), .rdRespValid(rdRespValid), .busReq(busReq),
    .busWrite(busWrite), .busReady(busReady), .busErr(busErr),
    .full(full), .empty(empty), .hit(hit), .strobe(strobe)
  );

  pwb_datapath #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stAddr(stAddr), .stData(stData),
    .rdAddr(rdAddr), .rdRespData(rdRespData), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .capClear(capClear),
    .errPulse(errPulse), .capValid(capValid), .capOverflow(capOverflow),
    .capAddr(capAddr), .full(full), .empty(empty), .hit(hit)
  );

  // R3: an outstanding write keeps address and data steady
  assert_write_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && !busReady) |=> ($stable(busAddr) && $stable(busWData)));
endmodule

// File: tb/tb_pwb_top.sv
`timescale 1ns/1ps
module tb_pwb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 4;
  localparam int NV = 8;

  // vector table: op 1 = store, 0 = read (data is the expected read value)
  localparam logic          V_OP   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [AW-1:0] V_ADDR [NV] = '{8'h10, 8'h11, 8'h10, 8'h10, 8'h11, 8'h22, 8'h22, 8'h22};
  localparam logic [DW-1:0] V_DATA [NV] = '{16'h1111, 16'h2222, 16'h3333, 16'h3333,
                                            16'h2222, 16'hA022, 16'h4444, 16'h4444};

  logic clk = 1'b0, rstN = 1'b0;
  logic stValid = 1'b0, rdValid = 1'b0, busReady = 1'b0, busErr = 1'b0, capClear = 1'b0;
  logic [AW-1:0] stAddr = '0, rdAddr = '0;
  logic [DW-1:0] stData = '0, busRData = '0;
  logic stReady, rdRespValid, busReq, busWrite, errPulse, capValid, capOverflow;
  logic [AW-1:0] busAddr, capAddr;
  logic [DW-1:0] busWData, rdRespData;

  int checkCnt = 0, failCnt = 0;
  int lat = 1, waitCnt = 0;
  logic [DW-1:0] mem [256];
  logic [AW-1:0] logAddr [128];
  logic          logWr [128];
  int logN = 0, errCnt = 0;

  pwb_top #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (.*);

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus model: completes after lat idle cycles; writes to 0x40..0x4F fail
  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 16'hA000 | 16'(a);
    forever begin
      @(negedge clk);
      if (busReq && !busReady) begin
        if (waitCnt >= lat) begin
          busReady = 1'b1;
          busRData = mem[busAddr];
          busErr   = busWrite && (busAddr[7:4] == 4'h4);
          if (busWrite && !busErr) mem[busAddr] = busWData;
          if (logN < 128) begin
            logAddr[logN] = busAddr;
            logWr[logN]   = busWrite;
            logN++;
          end
          waitCnt = 0;
        end else waitCnt++;
      end else begin
        busReady = 1'b0;
        busErr   = 1'b0;
      end
    end
  end

  always @(negedge clk) if (errPulse) errCnt++;

  task automatic doStore(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stData = d;
    #1;
    while (!stReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    stValid = 1'b0;
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [DW-1:0] d, output bit viaBus);
    @(negedge clk);
    rdValid = 1'b1; rdAddr = a;
    #1;
    while (!rdRespValid) begin @(negedge clk); #1; end
    d = rdRespData;
    viaBus = busReq;
    @(posedge clk); #1;
    rdValid = 1'b0;
  endtask

  task automatic waitDrained();
    int idle = 0;
    for (int n = 0; n < 500 && idle < 3; n++) begin
      @(negedge clk); #1;
      if (busReq) idle = 0; else idle++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    bit viaBus;
    int base;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(stReady == 1'b1 && busReq == 1'b0 && rdRespValid == 1'b0, "R1 handshake idle",
          {stReady, busReq, rdRespValid}, 3'b100);
    check(errPulse == 1'b0 && capValid == 1'b0 && capOverflow == 1'b0, "R1 capture clear",
          {errPulse, capValid, capOverflow}, 0);
    @(negedge clk); rstN = 1'b1;

    // table walk
    lat = 1;
    for (int v = 0; v < NV; v++) begin
      if (V_OP[v]) doStore(V_ADDR[v], V_DATA[v]);
      else begin
        doRead(V_ADDR[v], d, viaBus);
        check(d == V_DATA[v], "R5/R6 table read", d, V_DATA[v]);
      end
    end
    waitDrained();

    // R2: read pending blocks stores
    @(negedge clk);
    rdValid = 1'b1; rdAddr = 8'h90;
    #1;
    check(stReady == 1'b0, "R2 stReady low during read", stReady, 0);
    while (!rdRespValid) begin @(negedge clk); #1; end
    // R6: miss goes to the bus, response with busReady
    check(busReq && !busWrite && busReady && rdRespData == 16'hA090, "R6 miss read",
          rdRespData, 16'hA090);
    @(posedge clk); #1; rdValid = 1'b0;

    // R2: full queue deasserts stReady
    lat = 30;
    for (int k = 0; k < DEPTH; k++) doStore(8'h60 + 8'(k), 16'h6000 + 16'(k));
    @(negedge clk); #1;
    check(stReady == 1'b0, "R2 stReady low when full", stReady, 0);
    base = logN;
    doStore(8'h64, 16'h6004);
    waitDrained();
    // R3: drain order
    for (int k = 0; k <= DEPTH; k++)
      check(logWr[base + k] && logAddr[base + k] == 8'h60 + 8'(k), "R3 drain order",
            logAddr[base + k], 8'h60 + 8'(k));
    check(mem[8'h64] == 16'h6004, "R2 stalled store later written", mem[8'h64], 16'h6004);

    // R4: read overtakes a queued write
    lat = 3;
    base = logN;
    doStore(8'h30, 16'h3030);
    doStore(8'h31, 16'h3131);
    doRead(8'h50, d, viaBus);
    waitDrained();
    check(logAddr[base] == 8'h30 && logWr[base], "R4 first write", logAddr[base], 8'h30);
    check(logAddr[base + 1] == 8'h50 && !logWr[base + 1], "R4 read before second write",
          logAddr[base + 1], 8'h50);
    check(logAddr[base + 2] == 8'h31 && logWr[base + 2], "R4 second write after read",
          logAddr[base + 2], 8'h31);

    // R5: forwarding newest value, no bus read
    lat = 20;
    doStore(8'h70, 16'h5555);
    doStore(8'h71, 16'h6666);
    doStore(8'h71, 16'h7777);
    base = logN;
    doRead(8'h71, d, viaBus);
    check(d == 16'h7777, "R5 newest forwarded", d, 16'h7777);
    check(!viaBus && (logN == base || logWr[logN - 1]), "R5 no bus read", viaBus, 0);
    waitDrained();

    // R7/R8: first error
    lat = 0;
    base = errCnt;
    doStore(8'h40, 16'hDEAD);
    for (int n = 0; n < 50 && !(busReady && busErr); n++) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    check(errPulse == 1'b1, "R7 pulse after failing write", errPulse, 1);
    @(negedge clk); #1;
    check(errPulse == 1'b0 && errCnt == base + 1, "R7 single-cycle pulse", errCnt - base, 1);
    check(capValid && capAddr == 8'h40 && !capOverflow, "R8 first capture", capAddr, 8'h40);

    // R9: second error sets overflow only
    doStore(8'h44, 16'hBEEF);
    waitDrained();
    check(capOverflow && capAddr == 8'h40 && capValid, "R9 overflow keeps address",
          capAddr, 8'h40);

    // R10: clear
    @(negedge clk); capClear = 1'b1;
    @(posedge clk); #1; capClear = 1'b0;
    @(negedge clk); #1;
    check(!capValid && !capOverflow, "R10 clear", {capValid, capOverflow}, 0);

    // R10: clear colliding with a new failure
    doStore(8'h41, 16'h0001);
    waitDrained();
    lat = 3;
    doStore(8'h48, 16'h0002);
    for (int n = 0; n < 50 && !(busReady && busErr); n++) begin @(negedge clk); #1; end
    capClear = 1'b1;
    @(posedge clk); #1; capClear = 1'b0;
    @(negedge clk); #1;
    check(capValid && capAddr == 8'h48 && !capOverflow, "R10 clear with new failure",
          capAddr, 8'h48);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule